// File: doc/BRIEF.md
# Supply Monitor Reset and Interrupt Controller

This block is the digital control logic that sits behind a low-voltage comparator. It takes a "supply below threshold" result from one of two comparator sources, passes it through a synchronizer and samples it. Sampling happens on every clock in continuous mode, or on a periodic enable in intermittent mode. From the sampled result it keeps a live detection status and a sticky interrupt flag. It gates the flag with an interrupt enable to form the interrupt output. When a 4-bit key field holds the arming value, it also raises a system reset request.

While the reset request is active, the block protects itself. It switches to continuous sampling. It clears the sampling mode, the sampling interval and the interrupt enable, and returns its clock-control fields to their initial values. It keeps the threshold select, the source select, the key, the module enable and the flag. The request drops on its own once the live status shows a normal supply again. The mode and interval settings then stay cleared until software writes them again. Software uses a simple write port and a combinational read port to reach four registers.

Top module: `lvd_guard`

## Requirements
- R1: After reset, the registers read as follows: CTRL (address 0) reads 0x0000, CLKC (address 1) reads 0x0001 (debug-run bit 0 set, divider and source fields 0), STAT (address 2) reads 0x0000 and IE (address 3) reads 0x0000. The outputs irq_o, rst_req_o and det_o are 0.
- R2: CTRL bit 0 is the module enable. With CTRL bit 0 set and continuous mode selected (CTRL[3:2]=0), a change on the selected comparator input reaches det_o and STAT bit 1 on the third rising clock edge: two synchronizer stages, then the sample register. It is not visible after the second edge.
- R3: STAT bit 0, the flag, sets on the same edge that a low sample is taken. It stays set after the supply returns to normal.
- R4: irq_o is high exactly when the STAT flag and IE bit 0 are both 1.
- R5: Writing 1 to STAT bit 0 clears the flag. If a low sample is taken in the same cycle as that write, the flag stays set.
- R6: CTRL bit 1 selects the source. When it is 0, cmp_int_i is monitored. When it is 1, cmp_ext_i is monitored and cmp_int_i has no effect on det_o.
- R7: rst_req_o can assert only while the key field CTRL[15:12] equals 0xA. With any other key value, a low detection sets the flag but leaves rst_req_o at 0.
- R8: When the key is armed, rst_req_o rises on the same clock edge as the flag sets.
- R9: From the edge on which rst_req_o rises, and while it stays high, the following fields read as cleared or initial:
  - mode CTRL[3:2] reads 0;
  - interval CTRL[5:4] reads 0;
  - IE bit 0 reads 0;
  - CLKC reads 0x0001.

  Over the same period these fields keep their values: threshold select CTRL[10:6], source select CTRL[1], key CTRL[15:12], module enable CTRL[0] and the flag.
- R10: CTRL[3:2] nonzero selects intermittent mode. In this mode the sample register updates only once every 2^(2+CTRL[5:4]) clocks. With interval 1, a sampled low value therefore stays on det_o for 8 clocks after the input returns to normal.
- R11: While rst_req_o is high, all register writes are ignored.
- R12: rst_req_o falls on the same edge that det_o returns to 0. Afterwards, mode and interval keep their cleared values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_int_i | input | 1 | Internal comparator result, 1 = supply low |
| cmp_ext_i | input | 1 | External-pin comparator result, 1 = low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data, combinational |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | System reset request |
| det_o | output | 1 | Live sampled detection status |

## Verification
The embedded assertions guard, on every cycle, the following rules:
- the flag is sticky;
- a set takes priority over a clear;
- a reset request implies the arming key;
- the forced field values hold for the whole reset period;
- the key and threshold do not move during reset;
- release happens only with a normal status;
- intermittent sample pulses are isolated.

Only the bench scenarios can show the exact three-edge latency and the same-edge coincidence of flag and reset request. The same holds for the source selection, for interrupt gating and for the exact sampling period. They also cover the readback of the fields that are kept or cleared, and the settings that stay cleared after release.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int DW    = 16;
  localparam int AW    = 2;
  localparam int IVL_W = 2;
  localparam int MOD_W = 2;
  localparam int KEY_W = 4;
  localparam int THR_W = 5;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_CLKC = 2'd1;
  localparam logic [AW-1:0] A_STAT = 2'd2;
  localparam logic [AW-1:0] A_IE   = 2'd3;

  localparam logic [KEY_W-1:0] ARM_KEY = 4'hA;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic             rsv;
    logic [THR_W-1:0] thr;
    logic [IVL_W-1:0] ivl;
    logic [MOD_W-1:0] mode;
    logic             ext;
    logic             en;
  } ctrl_t;

  typedef struct packed {
    logic [9:0] rsv;
    logic [1:0] src;
    logic [2:0] div;
    logic       dbg;
  } clkc_t;

  localparam clkc_t CLKC_INIT = '{rsv: '0, src: '0, div: '0, dbg: 1'b1};
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lvd_sample_timer.sv
module lvd_sample_timer #(
  parameter int BASE_SHIFT = 2,
  parameter int IVL_W      = lvd_pkg::IVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intermittent_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             pulse_o
);
  localparam int CNT_W = BASE_SHIFT + (1 << IVL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, mask;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      mask[i] = (i < (BASE_SHIFT + int'(ivl_i)));
    end
  end

  always_comb begin
    cnt_d = intermittent_i ? cnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_o = !intermittent_i || ((cnt_q & mask) == mask);

  // R10: with period of at least two clocks, intermittent pulses never repeat back to back
  assert_pulse_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (intermittent_i && pulse_o) |=> (!intermittent_i || !pulse_o));
endmodule

// File: rtl/lvd_regs.sv
module lvd_regs
  import lvd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          det_sync_i,
  input  logic          sample_i,
  output ctrl_t         ctrl_o,
  output logic          det_o,
  output logic          flag_o,
  output logic          ie_o,
  output logic          rst_o
);
  ctrl_t ctrl_q, ctrl_d;
  clkc_t clkc_q, clkc_d;
  logic  ie_q, ie_d;
  logic  flag_q, flag_d;
  logic  det_q, det_d;
  logic  rst_q, rst_d;
  logic  wr_ok, set_ev, clr_ev, key_ok;

  always_comb begin
    wr_ok  = wr_en_i && !rst_q;
    set_ev = ctrl_q.en && sample_i && det_sync_i;
    clr_ev = wr_ok && (wr_addr_i == A_STAT) && wr_data_i[0];
    key_ok = (ctrl_q.key == ARM_KEY);

    det_d = 1'b0;
    if (ctrl_q.en) det_d = sample_i ? det_sync_i : det_q;

    rst_d  = key_ok && ctrl_q.en && det_d;
    flag_d = set_ev || (flag_q && !clr_ev);

    ctrl_d = ctrl_q;
    if (wr_ok && (wr_addr_i == A_CTRL)) ctrl_d = ctrl_t'(wr_data_i);
    ctrl_d.rsv = 1'b0;

    clkc_d = clkc_q;
    if (wr_ok && (wr_addr_i == A_CLKC)) clkc_d = clkc_t'(wr_data_i);
    clkc_d.rsv = '0;

    ie_d = ie_q;
    if (wr_ok && (wr_addr_i == A_IE)) ie_d = wr_data_i[0];

    if (rst_d) begin
      ctrl_d.mode = '0;
      ctrl_d.ivl  = '0;
      clkc_d      = CLKC_INIT;
      ie_d        = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      clkc_q <= CLKC_INIT;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      det_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      clkc_q <= clkc_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
      det_q  <= det_d;
      rst_q  <= rst_d;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = ctrl_q;
      A_CLKC:  rd_data_o = clkc_q;
      A_STAT:  rd_data_o = {{(DW-2){1'b0}}, det_q, flag_q};
      default: rd_data_o = {{(DW-1){1'b0}}, ie_q};
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign det_o  = det_q;
  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign rst_o  = rst_q;

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en_i && wr_addr_i == A_STAT && wr_data_i[0])) |=> flag_q);
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && sample_i && det_sync_i) |=> flag_q);
  assert_key_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (ctrl_q.key == ARM_KEY && ctrl_q.en));
  assert_rise_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> flag_q);
  assert_forced_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (ctrl_q.mode == '0 && ctrl_q.ivl == '0 && !ie_q && clkc_q == CLKC_INIT));
  assert_writes_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> ($stable(ctrl_q.key) && $stable(ctrl_q.thr) && $stable(ctrl_q.ext)));
  assert_release_normal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> !det_q);
endmodule

// File: rtl/lvd_guard.sv
module lvd_guard
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BASE_SHIFT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_int_i,
  input  logic          cmp_ext_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o,
  output logic          rst_req_o,
  output logic          det_o
);
  ctrl_t ctrl;
  logic  cmp_sel, det_sync, sample, flag, ie;

  assign cmp_sel = ctrl.ext ? cmp_ext_i : cmp_int_i;

  lvd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_sel),
    .q_o   (det_sync)
  );

  lvd_sample_timer #(.BASE_SHIFT(BASE_SHIFT), .IVL_W(IVL_W)) u_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .intermittent_i (ctrl.mode != '0),
    .ivl_i          (ctrl.ivl),
    .pulse_o        (sample)
  );

  lvd_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .det_sync_i (det_sync),
    .sample_i   (sample),
    .ctrl_o     (ctrl),
    .det_o      (det_o),
    .flag_o     (flag),
    .ie_o       (ie),
    .rst_o      (rst_req_o)
  );

  assign irq_o = flag && ie;
endmodule

// File: tb/lvd_guard_bench.sv
module lvd_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K_RD = 0, K_IRQ = 1, K_RST = 2, K_DET = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_int = 1'b0, cmp_ext = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        irq, rst_req, det;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int          q_kind[$];
  logic [1:0]  q_addr[$];
  logic [15:0] q_val[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lvd_guard u_lvd_guard (
    .clk(clk), .rst_n(rst_n), .cmp_int_i(cmp_int), .cmp_ext_i(cmp_ext),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_o(irq), .rst_req_o(rst_req), .det_o(det)
  );

  task automatic tally(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic expect_v(input int kind, input logic [1:0] a, input logic [15:0] v, input string tag);
    q_kind.push_back(kind); q_addr.push_back(a); q_val.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic drain();
    wait (q_kind.size() == 0);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: pops expectations and compares against the design outputs
  initial begin
    int k; logic [15:0] act;
    rd_addr = '0;
    forever begin
      @(negedge clk);
      #1;
      while (q_kind.size() > 0) begin
        k = q_kind.pop_front();
        rd_addr = q_addr.pop_front();
        #1;
        case (k)
          K_RD:    act = rd_data;
          K_IRQ:   act = {15'd0, irq};
          K_RST:   act = {15'd0, rst_req};
          default: act = {15'd0, det};
        endcase
        begin
          logic [15:0] e; string t;
          e = q_val.pop_front(); t = q_tag.pop_front();
          tally(act === e, t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tally(1'b0, "watchdog", 16'd0, 16'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    expect_v(K_RD, 2'd0, 16'h0000, "R1 CTRL"); expect_v(K_RD, 2'd1, 16'h0001, "R1 CLKC");
    expect_v(K_RD, 2'd2, 16'h0000, "R1 STAT"); drain(); step(1);
    expect_v(K_RD, 2'd3, 16'h0000, "R1 IE"); expect_v(K_IRQ, 0, 0, "R1 irq");
    expect_v(K_RST, 0, 0, "R1 rst"); drain(); step(1);
    expect_v(K_DET, 0, 0, "R1 det"); drain();

    // R2 latency, R3 flag set
    wr(2'd0, 16'h0001);
    cmp_int = 1'b1;
    step(2);
    expect_v(K_DET, 0, 0, "R2 det after two edges"); expect_v(K_RD, 2'd2, 16'h0000, "R3 flag not yet"); drain();
    step(1);
    expect_v(K_DET, 0, 1, "R2 det after three edges"); expect_v(K_RD, 2'd2, 16'h0003, "R3 flag set");
    expect_v(K_IRQ, 0, 0, "R4 irq masked"); drain();

    // R4 enable, R3 sticky
    wr(2'd3, 16'h0001);
    expect_v(K_IRQ, 0, 1, "R4 irq enabled"); drain();
    cmp_int = 1'b0;
    step(3);
    expect_v(K_DET, 0, 0, "R3 det normal"); expect_v(K_RD, 2'd2, 16'h0001, "R3 flag sticky");
    expect_v(K_IRQ, 0, 1, "R4 irq held"); drain();

    // R5 clear and set priority
    wr(2'd2, 16'h0001);
    expect_v(K_RD, 2'd2, 16'h0000, "R5 cleared"); expect_v(K_IRQ, 0, 0, "R4 irq off"); drain();
    cmp_int = 1'b1;
    step(3);
    wr(2'd2, 16'h0001);
    expect_v(K_RD, 2'd2, 16'h0003, "R5 set wins"); drain();
    cmp_int = 1'b0;
    step(3);
    wr(2'd2, 16'h0001);
    expect_v(K_RD, 2'd2, 16'h0000, "R5 clear after normal"); drain();

    // R6 source select
    wr(2'd0, 16'h0003);
    cmp_int = 1'b1;
    step(4);
    expect_v(K_DET, 0, 0, "R6 internal ignored"); expect_v(K_RD, 2'd2, 16'h0000, "R6 no flag"); drain();
    cmp_ext = 1'b1;
    step(3);
    expect_v(K_DET, 0, 1, "R6 external seen"); drain();
    cmp_ext = 1'b0; cmp_int = 1'b0;
    step(3);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h0001);

    // R7 wrong key
    wr(2'd0, 16'hB001);
    cmp_int = 1'b1;
    step(4);
    expect_v(K_RST, 0, 0, "R7 key 0xB no reset"); expect_v(K_RD, 2'd2, 16'h0003, "R7 flag set"); drain();
    cmp_int = 1'b0;
    step(3);
    wr(2'd2, 16'h0001);

    // R8 / R9 armed, continuous
    wr(2'd0, 16'hA001);
    wr(2'd1, 16'h003E);
    expect_v(K_RD, 2'd1, 16'h003E, "R9 CLKC written"); drain();
    wr(2'd3, 16'h0001);
    cmp_int = 1'b1;
    step(2);
    expect_v(K_RST, 0, 0, "R8 rst not yet"); expect_v(K_RD, 2'd2, 16'h0000, "R8 flag not yet"); drain();
    step(1);
    expect_v(K_RST, 0, 1, "R8 rst rises"); expect_v(K_RD, 2'd2, 16'h0003, "R8 flag same edge");
    expect_v(K_RD, 2'd3, 16'h0000, "R9 IE cleared"); drain();
    step(1);
    expect_v(K_RD, 2'd1, 16'h0001, "R9 CLKC init"); expect_v(K_RD, 2'd0, 16'hA001, "R9 CTRL kept");
    expect_v(K_IRQ, 0, 0, "R9 irq off"); drain();

    // R11 writes ignored
    wr(2'd0, 16'h0000);
    expect_v(K_RD, 2'd0, 16'hA001, "R11 CTRL write ignored"); drain();
    wr(2'd3, 16'h0001);
    expect_v(K_RD, 2'd3, 16'h0000, "R11 IE write ignored"); drain();

    // R12 release
    cmp_int = 1'b0;
    step(2);
    expect_v(K_RST, 0, 1, "R12 rst held"); drain();
    step(1);
    expect_v(K_RST, 0, 0, "R12 rst released"); expect_v(K_DET, 0, 0, "R12 det normal");
    expect_v(K_RD, 2'd2, 16'h0001, "R12 flag kept"); drain();
    wr(2'd2, 16'h0001);

    // R10 intermittent period
    wr(2'd0, 16'h0015);
    cmp_int = 1'b1;
    cnt = 0;
    while (!det && cnt < 40) begin step(1); cnt++; end
    tally(cnt >= 3 && cnt <= 10, "R10 first sample delay", 16'(cnt), 16'd10);
    cmp_int = 1'b0;
    step(7);
    expect_v(K_DET, 0, 1, "R10 held 7 clocks"); drain();
    step(1);
    expect_v(K_DET, 0, 0, "R10 updated at 8 clocks"); drain();
    wr(2'd2, 16'h0001);

    // R9 / R12 armed, intermittent
    wr(2'd0, 16'hA555);
    expect_v(K_RD, 2'd0, 16'hA555, "R9 CTRL intermittent"); drain();
    wr(2'd1, 16'h003E);
    wr(2'd3, 16'h0001);
    cmp_int = 1'b1;
    cnt = 0;
    while (!rst_req && cnt < 40) begin step(1); cnt++; end
    tally(rst_req, "R8 rst in intermittent", {15'd0, rst_req}, 16'd1);
    expect_v(K_RD, 2'd0, 16'hA541, "R9 mode and interval cleared"); expect_v(K_RD, 2'd3, 16'h0000, "R9 IE");
    expect_v(K_RD, 2'd1, 16'h0001, "R9 CLKC"); drain();
    step(1);
    expect_v(K_RD, 2'd2, 16'h0003, "R9 flag kept"); expect_v(K_IRQ, 0, 0, "R9 irq"); drain();
    cmp_int = 1'b0;
    step(3);
    expect_v(K_RST, 0, 0, "R12 released"); expect_v(K_RD, 2'd0, 16'hA541, "R12 mode stays cleared"); drain();

    step(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule